// File: doc/BRIEF.md
# Fast-Attack Coarse VGA Gain Controller

This block sets the gain code of a stepped analog variable-gain amplifier. It looks at the raw converter samples that come after that amplifier. A sample whose magnitude reaches the clip threshold is taken as converter saturation. It pulls the gain down by one step in the next cycle. After that, a blanking interval lets the analog path settle before any new sample is judged.

Gain is raised only slowly. The code moves up one step when a full window of consecutive valid samples has stayed below the low-level threshold with no clip. While the blanking interval runs, the window count is held at zero, so every decision rests on samples taken after settling. Each change of the code comes with a one-cycle strobe, so that a downstream fine gain loop can restart its averaging.

The total range (`RANGE_DB`) and the step size (`STEP_DB`) are parameters. The code counts steps from 0 up to `RANGE_DB/STEP_DB`, which is 18 with the default values.

Top module: `vga_coarse_ctrl`

## Requirements
- R1: After reset, `gain_code` equals the maximum code `GAIN_MAX` (18 by default), `gain_step` is 0 and `settling` is 0.
- R2: A valid sample is a clip when its two's-complement magnitude is at least `clip_thr`, for positive and negative samples alike. A clip taken while not settling lowers `gain_code` by exactly one in the following cycle.
- R3: After any gain change, `settling` is 1 for exactly `settle_len` cycles. Samples taken in those cycles do not change the gain.
- R4: The gain rises by one only when `QUIET_LEN` (32 by default) consecutive valid, non-settling samples all have a magnitude below `low_thr` and none is a clip. Any valid sample at or above `low_thr` restarts the count.
- R5: When one sample is both a clip and below `low_thr`, the clip wins. The gain goes down, not up.
- R6: The code saturates. It never goes below 0 or above `GAIN_MAX`. A request at a limit leaves the code unchanged, with no strobe and no blanking.
- R7: Low samples taken while settling do not count toward the quiet window. Counting starts from zero once `settling` falls.
- R8: Cycles with `smp_valid` at 0 neither count toward the quiet window, nor break it, nor cause a clip.
- R9: `gain_step` is high for exactly one cycle, the cycle in which `gain_code` shows a new value, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Converter sample, two's complement |
| clip_thr | input | SAMPLE_W | Magnitude at or above which a sample counts as a clip |
| low_thr | input | SAMPLE_W | Magnitude below which a sample counts as quiet |
| settle_len | input | SETTLE_W | Blanking length in clock cycles |
| gain_code | output | GAIN_W | VGA gain code in steps |
| gain_step | output | 1 | One-cycle strobe on every code change |
| settling | output | 1 | Blanking interval in progress |

## Verification
The step-down on a clip and the step-up at the end of a quiet window can fall in the same cycle. To provoke this, the bench raises `low_thr` above `clip_thr`, sends 31 quiet samples, and then sends a full-scale sample as the 32nd. The scoreboard must then see a single strobe with the code one step lower, not higher. A second collision happens when a clip arrives in the very first cycle after blanking ends. The bench times clips to land exactly there and expects them to act, while clips one cycle earlier must not.

// File: rtl/vga_ctrl_pkg.sv
package vga_ctrl_pkg;

  // Per-sample classification produced by the magnitude detector
  typedef struct packed {
    logic clip;   // valid sample with magnitude >= clip threshold
    logic low;    // valid sample with magnitude <  low threshold
  } det_t;

  // Two's-complement magnitude; the most negative code maps to 2^(W-1)
  function automatic logic [31:0] mag32(input logic [31:0] v, input int w);
    logic [31:0] m;
    m = v[w-1] ? (~v + 32'd1) : v;
    return m & ((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/vga_mag_detect.sv
module vga_mag_detect
  import vga_ctrl_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] clip_thr,
  input  logic [SAMPLE_W-1:0] low_thr,
  output det_t                det
);

  logic [SAMPLE_W-1:0] mag;

  always_comb begin
    mag      = smp_data[SAMPLE_W-1] ? (~smp_data + 1'b1) : smp_data;
    det.clip = smp_valid && (mag >= clip_thr);
    det.low  = smp_valid && (mag <  low_thr);
  end

endmodule

// File: rtl/vga_settle_timer.sv
module vga_settle_timer #(
  parameter int SETTLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                busy
);

  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/vga_quiet_window.sv
module vga_quiet_window
  import vga_ctrl_pkg::*;
#(
  parameter int QUIET_LEN = 32,
  localparam int QW = $clog2(QUIET_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blank,
  input  logic smp_valid,
  input  det_t det,
  output logic full
);

  localparam logic [QW-1:0] LAST = QW'(QUIET_LEN - 1);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          quiet;

  always_comb begin
    quiet  = det.low && !det.clip;
    full   = !blank && quiet && (cnt_q == LAST);
    cnt_en = blank || smp_valid;
    if (blank || !quiet || full) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/vga_gain_reg.sv
module vga_gain_reg #(
  parameter int GAIN_MAX = 18,
  localparam int GAIN_W = $clog2(GAIN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_req,
  input  logic              inc_req,
  output logic              change,
  output logic [GAIN_W-1:0] gain_q,
  output logic              step_q
);

  localparam logic [GAIN_W-1:0] TOP = GAIN_W'(GAIN_MAX);

  logic              go_dn, go_up;
  logic [GAIN_W-1:0] gain_d;

  always_comb begin
    go_dn  = dec_req && (gain_q != '0);
    go_up  = inc_req && !dec_req && (gain_q != TOP);
    change = go_dn || go_up;
    gain_d = go_dn ? gain_q - 1'b1 : gain_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gain_q <= TOP;
    else if (change) gain_q <= gain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 1'b0;
    else        step_q <= change;
  end

endmodule

// File: rtl/vga_coarse_ctrl.sv
module vga_coarse_ctrl
  import vga_ctrl_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int SETTLE_W  = 10,
  parameter int RANGE_DB  = 36,
  parameter int STEP_DB   = 2,
  parameter int QUIET_LEN = 32,
  localparam int GAIN_MAX = RANGE_DB / STEP_DB,
  localparam int GAIN_W   = $clog2(GAIN_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] clip_thr,
  input  logic [SAMPLE_W-1:0] low_thr,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic [GAIN_W-1:0]   gain_code,
  output logic                gain_step,
  output logic                settling
);

  det_t det;
  logic busy, quiet_full, change;
  logic dec_req, inc_req;

  vga_mag_detect #(.SAMPLE_W(SAMPLE_W)) u_det (
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .clip_thr  (clip_thr),
    .low_thr   (low_thr),
    .det       (det)
  );

  vga_quiet_window #(.QUIET_LEN(QUIET_LEN)) u_quiet (
    .clk       (clk),
    .rst_n     (rst_n),
    .blank     (busy),
    .smp_valid (smp_valid),
    .det       (det),
    .full      (quiet_full)
  );

  // clip beats quiet-window completion; nothing acts while blanking
  always_comb begin
    dec_req = !busy && det.clip;
    inc_req = !busy && quiet_full;
  end

  vga_gain_reg #(.GAIN_MAX(GAIN_MAX)) u_gain (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_req (dec_req),
    .inc_req (inc_req),
    .change  (change),
    .gain_q  (gain_code),
    .step_q  (gain_step)
  );

  vga_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (change),
    .load_val (settle_len),
    .busy     (busy)
  );

  assign settling = busy;

endmodule

// File: rtl/vga_coarse_ctrl_chk.sv
module vga_coarse_ctrl_chk #(
  parameter int SAMPLE_W  = 12,
  parameter int SETTLE_W  = 10,
  parameter int GAIN_MAX  = 18,
  parameter int GAIN_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic [SAMPLE_W-1:0] clip_thr,
  input logic [SETTLE_W-1:0] settle_len,
  input logic [GAIN_W-1:0]   gain_code,
  input logic                gain_step,
  input logic                settling
);

  logic [SAMPLE_W-1:0] mag;
  logic                clip_now;
  assign mag      = smp_data[SAMPLE_W-1] ? (~smp_data + 1'b1) : smp_data;
  assign clip_now = smp_valid && (mag >= clip_thr);

  // R6: code stays in range
  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code <= GAIN_W'(GAIN_MAX));

  // R6: code moves by at most one step per cycle
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gain_code == $past(gain_code)) ||
             (gain_code == GAIN_W'($past(gain_code) + 1'b1)) ||
             (gain_code == GAIN_W'($past(gain_code) - 1'b1)));

  // R2: clip while idle and above minimum pulls the code down
  a_r2_clip_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!settling && clip_now && gain_code != '0) |=>
      (gain_code == GAIN_W'($past(gain_code) - 1'b1)));

  // R3: no change while blanking
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    settling |=> $stable(gain_code));

  // R3: blanking starts with the change
  a_r3_busy_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_step && settle_len != '0) |-> settling);

  // R9: strobe marks exactly the cycles with a new code
  a_r9_strobe_change: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gain_step == (gain_code != $past(gain_code))));

endmodule

bind vga_coarse_ctrl vga_coarse_ctrl_chk #(
  .SAMPLE_W (SAMPLE_W),
  .SETTLE_W (SETTLE_W),
  .GAIN_MAX (GAIN_MAX),
  .GAIN_W   (GAIN_W)
) u_chk (.*);

// File: tb/tb_vga_coarse_ctrl.sv
`timescale 1ns/1ps
module tb_vga_coarse_ctrl;

  localparam int SAMPLE_W = 12;
  localparam int SETTLE_W = 10;
  localparam int GMAX     = 18;
  localparam int GW       = 5;
  localparam int QLEN     = 32;
  localparam int SETL     = 5;

  logic                clk, rst_n, smp_valid;
  logic [SAMPLE_W-1:0] smp_data, clip_thr, low_thr;
  logic [SETTLE_W-1:0] settle_len;
  logic [GW-1:0]       gain_code;
  logic                gain_step, settling;

  int total = 0;
  int bad   = 0;
  int exp_q[$];
  string tag_q[$];

  vga_coarse_ctrl dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_gain(input int g, input string req);
    exp_q.push_back(g);
    tag_q.push_back(req);
  endtask

  task automatic send(input logic v, input int val);
    @(negedge clk);
    smp_valid = v;
    smp_data  = SAMPLE_W'(val);
    @(posedge clk);
    #2 smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && gain_step) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected strobe", int'(gain_code), -1);
      end else begin
        string t;
        int    e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(gain_code), e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
    clip_thr = 12'd2000; low_thr = 12'd100; settle_len = SETTLE_W'(SETL);
    idle(3);
    check("R1 gain reset", int'(gain_code), GMAX);
    check("R1 strobe reset", int'(gain_step), 0);
    check("R1 settling reset", int'(settling), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R2 positive clip, R3 blanking length
    expect_gain(17, "R2 clip down pos");
    send(1, 2047);
    check("R3 settling after step", int'(settling), 1);
    repeat (4) send(1, 2047);
    check("R3 still settling", int'(settling), 1);
    check("R3 gain held", int'(gain_code), 17);
    send(1, 2047);
    check("R3 settling ended", int'(settling), 0);
    check("R3 gain held end", int'(gain_code), 17);
    // clip in first cycle after blanking acts; negative full scale
    expect_gain(16, "R2 clip down neg");
    send(1, -2048);
    idle(SETL + 1);

    // R4 quiet window with restart
    repeat (31) send(1, 10);
    check("R4 no rise at 31", int'(gain_code), 16);
    send(1, 500);
    repeat (31) send(1, 10);
    check("R4 restart after loud", int'(gain_code), 16);
    expect_gain(17, "R4 rise after window");
    send(1, 10);
    idle(SETL + 1);

    // R8 invalid cycles neither count nor break
    repeat (16) send(1, 10);
    repeat (10) send(0, 2047);
    repeat (15) send(1, 10);
    check("R8 invalid not counted", int'(gain_code), 17);
    expect_gain(18, "R8 rise across gaps");
    send(1, 10);
    idle(SETL + 1);

    // R6 top saturation
    repeat (QLEN + 4) send(1, 10);
    check("R6 hold at max", int'(gain_code), GMAX);
    check("R6 no blanking at max", int'(settling), 0);
    check("R9 no pending strobe", exp_q.size(), 0);

    // R7 samples during blanking do not count
    expect_gain(17, "R7 clip");
    send(1, 2047);
    repeat (SETL) send(1, 10);
    repeat (31) send(1, 10);
    check("R7 window from zero", int'(gain_code), 17);
    expect_gain(18, "R7 rise");
    send(1, 10);
    idle(SETL + 1);

    // R5 collision: last window sample is also a clip
    low_thr = 12'd4095;
    repeat (31) send(1, 10);
    expect_gain(17, "R5 clip beats rise");
    send(1, 2047);
    idle(SETL + 1);
    check("R5 single step down", int'(gain_code), 17);
    low_thr = 12'd100;

    // R6 bottom saturation
    for (int g = 16; g >= 0; g--) begin
      expect_gain(g, "R6 walk down");
      send(1, 2047);
      repeat (SETL) send(1, -2047);
    end
    repeat (10) send(1, 2047);
    check("R6 hold at zero", int'(gain_code), 0);
    check("R6 no blanking at zero", int'(settling), 0);
    idle(2);
    check("R9 queue drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule